// File: doc/BRIEF.md
# Timestamped Record Arbiter

This block sits between four logging sources and a shared output word stream. Each source announces a sampling moment with a one-cycle timestamp request and later raises a ready flag once it has data to hand over. The block turns every request edge into a level request that it holds towards a timestamp store until the store answers with a grant. A channel that has both a granted timestamp and a raised ready flag becomes a candidate for the output.

When the output is free, the lowest-numbered candidate wins and is served for one complete record of 32 sixteen-bit words (64 bytes). The first four words come from the timestamp store, addressed by a word select and the channel number. The remaining 28 words come from the channel itself, which is told to advance its read address by a one-cycle next-word pulse per word. If the source drops its ready flag part-way through, zero words take its place so that the record keeps its fixed length. Two register stages form the output word: the first picks the source word and its ready flag by channel, the second picks between the timestamp word, the source word and zero. A counter tallies finished records. The channel numbering used by the surrounding logger is 0 for inertial samples, 1 for decoded positioning sentences, 2 for external frame-sync times and 3 for software messages.

Top module: `log_record_arbiter`

## Requirements
- R1: After reset the held requests, word_valid, rec_valid, src_next and sample_count are all zero.
- R2: A rising edge on ts_req_in[i] sets ts_req_hold[i] on the next clock edge; the hold stays set while no grant arrives, and a request input that stays high produces no further request after the grant.
- R3: A grant on ts_grant[i] while ts_req_hold[i] is set and ts_req_in[i] is low clears ts_req_hold[i] on the next clock edge.
- R4: A channel is served only once its timestamp has been granted and its src_ready bit is 1; when several qualify at once the lowest index is served first, and each grant allows exactly one record.
- R5: A record is 32 consecutive cycles of word_valid; in the first four ts_pick is 1 and ts_word_sel counts 0, 1, 2, 3; in the other 28 ts_pick is 0.
- R6: src_next carries exactly one bit, that of chan_sel, in each data word of a record and is all zero in timestamp words and between records.
- R7: rec_valid follows word_valid by exactly two clock cycles; a timestamp word carries the ts_data present during its word cycle and a data word carries the selected channel's src_data slice present during its word cycle.
- R8: A data word whose cycle sees src_ready of the served channel at 0 is output as 16'h0000, and the record still completes all 32 words.
- R9: chan_sel is constant throughout a record; a lower-numbered channel that qualifies during a record is served only after that record ends.
- R10: sample_count increases by exactly one at the end of each record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ts_req_in | input | NCH | One-cycle timestamp request per channel (edge counts) |
| ts_grant | input | NCH | Grant from the timestamp store per channel |
| src_ready | input | NCH | Per-channel data ready flag |
| src_data | input | NCH*DW | Current read word of every channel, channel i in slice i |
| ts_data | input | DW | Timestamp word addressed by chan_sel and ts_word_sel |
| ts_req_hold | output | NCH | Held timestamp requests towards the store |
| src_next | output | NCH | Next-word pulse to the served channel |
| chan_sel | output | CH_W | Channel being served |
| ts_word_sel | output | TSW_W | Timestamp word index within the record |
| ts_pick | output | 1 | Current word is a timestamp word |
| word_valid | output | 1 | A record word is being issued this cycle |
| rec_data | output | DW | Registered output word |
| rec_valid | output | 1 | rec_data holds a record word |
| sample_count | output | CNT_W | Number of finished records |

## Verification
The bench uses the default build: four channels, 16-bit words, four timestamp words, 32-word records and a 16-bit counter. With records that short, every word of every record is compared against a source model whose words encode channel and read address, so both misordered next pulses and a wrong two-stage latency show up as data mismatches. The four-channel build also makes the priority, the no-preemption window and the mid-record loss of ready reachable within a few records.

// File: rtl/log_record_arbiter.sv
module log_record_arbiter #(
  parameter int NCH       = 4,
  parameter int DW        = 16,
  parameter int TS_WORDS  = 4,
  parameter int REC_WORDS = 32,
  parameter int CNT_W     = 16,
  localparam int CH_W     = $clog2(NCH),
  localparam int TSW_W    = $clog2(TS_WORDS),
  localparam int WC_W     = $clog2(REC_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ts_req_in,
  input  logic [NCH-1:0]    ts_grant,
  input  logic [NCH-1:0]    src_ready,
  input  logic [NCH*DW-1:0] src_data,
  input  logic [DW-1:0]     ts_data,
  output logic [NCH-1:0]    ts_req_hold,
  output logic [NCH-1:0]    src_next,
  output logic [CH_W-1:0]   chan_sel,
  output logic [TSW_W-1:0]  ts_word_sel,
  output logic              ts_pick,
  output logic              word_valid,
  output logic [DW-1:0]     rec_data,
  output logic              rec_valid,
  output logic [CNT_W-1:0]  sample_count
);

  logic [NCH-1:0]  req_d, req_q, got_q, elig, claim;
  logic            busy;
  logic [WC_W-1:0] wcnt;
  logic [CH_W-1:0] chan_q, pick;
  logic            any;
  logic [DW-1:0]   s1_src, s1_ts;
  logic            s1_rdy, s1_pick, s1_valid;

  assign elig = got_q & src_ready;
  assign any  = |elig;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) pick = CH_W'(i);
  end

  assign claim       = (!busy && any) ? (NCH'(1) << pick) : '0;
  assign ts_req_hold = req_q;
  assign chan_sel    = chan_q;
  assign word_valid  = busy;
  assign ts_pick     = busy && (wcnt < WC_W'(TS_WORDS));
  assign ts_word_sel = wcnt[TSW_W-1:0];
  assign src_next    = (busy && !ts_pick) ? (NCH'(1) << chan_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d        <= '0;
      req_q        <= '0;
      got_q        <= '0;
      busy         <= 1'b0;
      wcnt         <= '0;
      chan_q       <= '0;
      sample_count <= '0;
    end else begin
      req_d <= ts_req_in;
      req_q <= (req_q & ~ts_grant) | (ts_req_in & ~req_d);
      got_q <= (got_q | (req_q & ts_grant)) & ~claim;
      if (!busy) begin
        if (any) begin
          busy   <= 1'b1;
          chan_q <= pick;
          wcnt   <= '0;
        end
      end else begin
        wcnt <= wcnt + 1'b1;
        if (wcnt == WC_W'(REC_WORDS - 1)) begin
          busy         <= 1'b0;
          sample_count <= sample_count + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_src    <= '0;
      s1_ts     <= '0;
      s1_rdy    <= 1'b0;
      s1_pick   <= 1'b0;
      s1_valid  <= 1'b0;
      rec_data  <= '0;
      rec_valid <= 1'b0;
    end else begin
      s1_src    <= src_data[chan_q*DW +: DW];
      s1_rdy    <= src_ready[chan_q];
      s1_ts     <= ts_data;
      s1_pick   <= ts_pick;
      s1_valid  <= busy;
      rec_data  <= s1_pick ? s1_ts : (s1_rdy ? s1_src : '0);
      rec_valid <= s1_valid;
    end
  end

endmodule

// File: rtl/log_record_arbiter_chk.sv
module log_record_arbiter_chk #(
  parameter int NCH      = 4,
  parameter int TS_WORDS = 4,
  parameter int CNT_W    = 16,
  localparam int CH_W    = $clog2(NCH),
  localparam int TSW_W   = $clog2(TS_WORDS)
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   ts_req_in,
  input logic [NCH-1:0]   ts_grant,
  input logic [NCH-1:0]   ts_req_hold,
  input logic [NCH-1:0]   src_next,
  input logic [CH_W-1:0]  chan_sel,
  input logic [TSW_W-1:0] ts_word_sel,
  input logic             ts_pick,
  input logic             word_valid,
  input logic             rec_valid,
  input logic [CNT_W-1:0] sample_count
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_hold_until_grant_r2: assert property (@(posedge clk) disable iff (rst)
      (ts_req_hold[i] && !ts_grant[i]) |=> ts_req_hold[i]);
    p_grant_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (ts_req_hold[i] && ts_grant[i] && !ts_req_in[i]) |=> !ts_req_hold[i]);
  end

  p_next_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_next));
  p_no_next_in_ts_r6: assert property (@(posedge clk) disable iff (rst)
    (ts_pick || !word_valid) |-> (src_next == '0));
  p_first_word_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(word_valid) |-> (ts_pick && ts_word_sel == '0));
  p_ts_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ts_pick && ts_word_sel != TSW_W'(TS_WORDS - 1)) |=>
      (ts_pick && ts_word_sel == $past(ts_word_sel) + 1'b1));
  p_lag_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> ##1 rec_valid);
  p_no_stray_r7: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> ##1 !rec_valid);
  p_chan_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (word_valid && $past(word_valid) && !$rose(ts_pick)) |-> $stable(chan_sel));
  p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
    (sample_count != $past(sample_count)) |->
      (sample_count == $past(sample_count) + 1'b1));

endmodule

bind log_record_arbiter log_record_arbiter_chk #(
  .NCH(NCH), .TS_WORDS(TS_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .ts_req_in(ts_req_in), .ts_grant(ts_grant),
  .ts_req_hold(ts_req_hold), .src_next(src_next), .chan_sel(chan_sel),
  .ts_word_sel(ts_word_sel), .ts_pick(ts_pick), .word_valid(word_valid),
  .rec_valid(rec_valid), .sample_count(sample_count)
);

// File: tb/log_record_arbiter_tb.sv
`timescale 1ns/1ps
module log_record_arbiter_tb;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    ts_req_in = '0;
  logic [NCH-1:0]    ts_grant  = '0;
  logic [NCH-1:0]    src_ready = '0;
  logic [NCH*DW-1:0] src_data;
  logic [DW-1:0]     ts_data;
  logic [NCH-1:0]    ts_req_hold, src_next;
  logic [1:0]        chan_sel, ts_word_sel;
  logic              ts_pick, word_valid, rec_valid;
  logic [DW-1:0]     rec_data;
  logic [15:0]       sample_count;

  always #5 clk = ~clk;

  log_record_arbiter u_dut (
    .clk(clk), .rst(rst), .ts_req_in(ts_req_in), .ts_grant(ts_grant),
    .src_ready(src_ready), .src_data(src_data), .ts_data(ts_data),
    .ts_req_hold(ts_req_hold), .src_next(src_next), .chan_sel(chan_sel),
    .ts_word_sel(ts_word_sel), .ts_pick(ts_pick), .word_valid(word_valid),
    .rec_data(rec_data), .rec_valid(rec_valid), .sample_count(sample_count)
  );

  // source model: word = {channel, 4'h0, read address}
  logic [7:0] addr [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_src
    assign src_data[g*DW +: DW] = {4'(g), 4'h0, addr[g]};
    always @(posedge clk) begin
      if (rst) addr[g] <= '0;
      else if (src_next[g]) addr[g] <= addr[g] + 8'd1;
    end
  end
  assign ts_data = {12'hA00, chan_sel, ts_word_sel};

  int tests = 0, fails = 0;
  int wv_total = 0, rv_total = 0;
  int chan_err = 0, pick_err = 0, next_err = 0;
  logic [DW-1:0] rec_buf [256];
  logic [1:0]    chan_log [8];
  int exp_addr [NCH];

  always @(negedge clk) begin
    if (!rst && word_valid) begin
      automatic int w = wv_total % 32;
      automatic int r = wv_total / 32;
      automatic logic [NCH-1:0] en;
      if (w == 0) chan_log[r % 8] = chan_sel;
      else if (chan_sel != chan_log[r % 8]) chan_err++;
      if (ts_pick != (w < 4)) pick_err++;
      if (ts_pick && ts_word_sel != 2'(w)) pick_err++;
      en = ts_pick ? '0 : (NCH'(1) << chan_sel);
      if (src_next != en) next_err++;
      wv_total++;
    end
    if (!rst && !word_valid && src_next != '0) next_err++;
    if (!rst && rec_valid) begin
      rec_buf[rv_total % 256] = rec_data;
      rv_total++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input int ch);
    @(negedge clk) ts_req_in[ch] = 1'b1;
    @(negedge clk) ts_req_in[ch] = 1'b0;
  endtask

  task automatic give_grant(input int ch);
    @(negedge clk) ts_grant[ch] = 1'b1;
    @(negedge clk) ts_grant[ch] = 1'b0;
  endtask

  task automatic wait_records(input int n);
    for (int i = 0; i < 3000 && rv_total < 32 * n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_record(input int r, input int ch, input int nvalid);
    int bad = 0, first_w = -1;
    logic [DW-1:0] exp, act, fe = '0, fa = '0;
    for (int w = 0; w < 32; w++) begin
      if (w < 4) exp = {12'hA00, 2'(ch), 2'(w)};
      else if (w - 4 < nvalid) exp = {4'(ch), 4'h0, 8'(exp_addr[ch] + w - 4)};
      else exp = '0;
      act = rec_buf[(r * 32 + w) % 256];
      if (act !== exp) begin
        bad++;
        if (first_w < 0) begin first_w = w; fe = exp; fa = act; end
      end
    end
    chk(bad == 0, $sformatf("R7 R8 record %0d word %0d", r, first_w), fa, fe);
    chk(chan_log[r % 8] == 2'(ch), $sformatf("R4 record %0d channel", r),
        chan_log[r % 8], ch);
    exp_addr[ch] += 28;
  endtask

  task automatic t_reset();
    chk(ts_req_hold == '0, "R1 hold", ts_req_hold, 0);
    chk(!word_valid && !rec_valid, "R1 valid", {word_valid, rec_valid}, 0);
    chk(src_next == '0, "R1 next", src_next, 0);
    chk(sample_count == 0, "R1 count", sample_count, 0);
  endtask

  task automatic t_hold();
    pulse_req(1);
    repeat (4) @(negedge clk);
    chk(ts_req_hold[1], "R2 held after one-cycle pulse", ts_req_hold, 2);
    @(negedge clk) ts_req_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk(ts_req_hold[0], "R2 level input held", ts_req_hold, 3);
    ts_grant[0] = 1'b1;
    @(negedge clk) ts_grant[0] = 1'b0;
    chk(!ts_req_hold[0], "R3 grant clears hold", ts_req_hold, 2);
    repeat (3) @(negedge clk);
    chk(!ts_req_hold[0], "R2 steady input no new request", ts_req_hold, 2);
    ts_req_in[0] = 1'b0;
    give_grant(1);
    chk(ts_req_hold == '0, "R3 second grant", ts_req_hold, 0);
    repeat (5) @(negedge clk);
    chk(wv_total == 0, "R4 granted but not ready", wv_total, 0);
  endtask

  task automatic t_priority();
    @(negedge clk) src_ready[1:0] = 2'b11;
    wait_records(2);
    chk(rv_total == 64, "R5 two records word count", rv_total, 64);
    check_record(0, 0, 28);
    check_record(1, 1, 28);
    chk(sample_count == 2, "R10 count after two", sample_count, 2);
    chk(pick_err == 0, "R5 timestamp word order", pick_err, 0);
    chk(next_err == 0, "R6 next pulses", next_err, 0);
  endtask

  task automatic t_zero_fill();
    pulse_req(2);
    @(negedge clk) src_ready[2] = 1'b1;
    give_grant(2);
    for (int i = 0; i < 100 && !word_valid; i++) @(negedge clk);
    repeat (9) @(negedge clk);
    src_ready[2] = 1'b0;
    wait_records(3);
    chk(rv_total == 96, "R8 record completes", rv_total, 96);
    check_record(2, 2, 5);
  endtask

  task automatic t_no_preempt();
    pulse_req(3);
    @(negedge clk) src_ready[3] = 1'b1;
    give_grant(3);
    for (int i = 0; i < 100 && !word_valid; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    pulse_req(0);
    give_grant(0);
    @(negedge clk);
    chk(chan_sel == 2'd3 && word_valid, "R9 record not preempted", chan_sel, 3);
    wait_records(5);
    check_record(3, 3, 28);
    check_record(4, 0, 28);
    chk(chan_err == 0, "R9 channel stable in record", chan_err, 0);
    chk(sample_count == 5, "R10 count after five", sample_count, 5);
  endtask

  task automatic t_needs_grant();
    repeat (60) @(negedge clk);
    chk(wv_total == 160, "R4 ready without grant is not served", wv_total, 160);
    chk(next_err == 0 && pick_err == 0, "R6 next pulses overall",
        next_err + pick_err, 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_addr[c] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_hold();
    t_priority();
    t_zero_fill();
    t_no_preempt();
    t_needs_grant();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule